// File: doc/BRIEF.md
# Linked-List DMA Node Walker

This block is one DMA channel that copies 32-bit words from memory to a peripheral FIFO by walking a chain of nodes in memory. Software loads the channel's address register while the channel is idle and then pulses start. The walker fetches the node header found at that address. The header's top byte is a word count and its low 24 bits point to the next node. The walker reads the counted payload words that follow the header and hands each one to the peripheral port. When the node is finished it follows the link.

A link whose bit 23 is set is an end marker, whatever its other bits hold. After the node that carries it, the walker stops, drops busy, pulses done and leaves the end marker in the address register. While the transfer runs, that register always holds the start address of the node being worked on. If enable is cleared, the walker stops cleanly at the next word boundary. A later start then replays the interrupted node from its header.

Top module: `llist_dma`

## Requirements
- R1: On start while enable is high and the channel is idle, busy rises and the first header is read from the address register's value with bits 1:0 cleared.
- R2: A header word carries the payload word count in bits 31:24 and the next-node address in bits 23:0. The payload words sit at the header address plus 4, 8, and so on, and reach the peripheral in that order.
- R3: A node whose count is zero transfers no payload and goes straight on to its link.
- R4: The walk ends after the current node whenever bit 23 of its link is set. Any value with that bit set counts, not only 0xFFFFFF.
- R5: While busy, the address register reads as the start address of the node in progress. After a finished walk it reads the end marker. Every address the walker stores or drives has bits 1:0 at zero, including links stored with those bits set.
- R6: While idle, a write to the address register stores all 24 bits, bits 1:0 included, and reads back unchanged.
- R7: A payload word offered with per_valid waits, with its data unchanged, until per_ready is high. Each word is delivered exactly once.
- R8: When the end marker is reached, done is high for exactly one cycle, and busy is low in that same cycle.
- R9: If enable is low when a payload word is accepted, the walker stops after that word, without done and with the address register left at the node's start. A later start replays that node from its header.
- R10: Address register writes made while busy are ignored.
- R11: A memory read request keeps mem_req high and mem_addr stable until mem_valid returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable; low stops the walk at a word boundary |
| start | input | 1 | Begin a walk (idle only) |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | 24 | Address register write value |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at walk end |
| cur_addr | output | 24 | Address register read value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| per_valid | output | 1 | Payload word offered |
| per_data | output | 32 | Payload word |
| per_ready | input | 1 | Peripheral accepts the offered word |

## Verification
The assertions take for granted that memory raises mem_valid only while mem_req is high, and that it returns data only after the request has been seen at a clock edge. The bench's memory model answers each request after a varying delay of zero to two cycles. It lowers mem_valid again in the cycle after each answer, so a response never covers a request that was not made. Payload backpressure follows a per_ready pattern that the bench changes between runs. Enable is dropped only at the point where a payload word is accepted, which is the boundary that R9 defines.

// File: rtl/llist_dma.sv
module llist_dma #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_wdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] cur_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          per_valid,
  output logic [DW-1:0] per_data,
  input  logic          per_ready
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_RD, S_WR} st_t;

  st_t           state;
  logic [AW-1:0] madr, ptr, link;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wbuf;
  logic          done_q;

  logic [AW-1:0] nxt_raw, nxt_addr;
  logic          nxt_last;
  st_t           nxt_state;

  assign nxt_raw  = (state == S_HDR) ? mem_rdata[AW-1:0] : link;
  assign nxt_addr = {nxt_raw[AW-1:2], 2'b00};
  assign nxt_last = nxt_raw[AW-1];

  always_comb begin
    if (nxt_last || !en) nxt_state = S_IDLE;
    else                 nxt_state = S_HDR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      madr   <= '0;
      ptr    <= '0;
      link   <= '0;
      cnt    <= '0;
      wbuf   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (addr_we) madr <= addr_wdata;
          else if (start && en) begin
            madr  <= {madr[AW-1:2], 2'b00};
            state <= S_HDR;
          end
        end
        S_HDR: begin
          if (mem_valid) begin
            link <= mem_rdata[AW-1:0];
            cnt  <= mem_rdata[DW-1:DW-CW];
            ptr  <= madr + STEP;
            if (mem_rdata[DW-1:DW-CW] == '0) begin
              madr   <= nxt_addr;
              state  <= nxt_state;
              done_q <= nxt_last;
            end else begin
              state <= S_RD;
            end
          end
        end
        S_RD: begin
          if (mem_valid) begin
            wbuf  <= mem_rdata;
            state <= S_WR;
          end
        end
        S_WR: begin
          if (per_ready) begin
            cnt <= cnt - 1'b1;
            ptr <= ptr + STEP;
            if (cnt == CW'(1)) begin
              madr   <= nxt_addr;
              state  <= nxt_state;
              done_q <= nxt_last;
            end else if (!en) begin
              state <= S_IDLE;
            end else begin
              state <= S_RD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign cur_addr  = madr;
  assign mem_req   = (state == S_HDR) || (state == S_RD);
  assign mem_addr  = (state == S_HDR) ? madr : ptr;
  assign per_valid = (state == S_WR);
  assign per_data  = wbuf;

  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid && !per_ready |=> per_valid && $stable(per_data));

  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r4_end_marker: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cur_addr[AW-1] && cur_addr[1:0] == 2'b00);

  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_addr[1:0] == 2'b00 && mem_addr[1:0] == 2'b00);

  a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && en && !addr_we |=> busy && mem_req);
endmodule

// File: tb/llist_dma_tb.sv
module llist_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_main = 1'b0, abort_hit = 1'b0, en;
  logic        start = 1'b0, addr_we = 1'b0;
  logic [23:0] addr_wdata = '0;
  logic        busy, done, mem_req, per_valid;
  logic [23:0] cur_addr, mem_addr;
  logic        mem_valid = 1'b0, per_ready = 1'b0;
  logic [31:0] mem_rdata = '0, per_data;

  assign en = en_main && !abort_hit;

  llist_dma u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start),
    .addr_we(addr_we), .addr_wdata(addr_wdata),
    .busy(busy), .done(done), .cur_addr(cur_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .per_valid(per_valid), .per_data(per_data), .per_ready(per_ready)
  );

  always #5 clk = ~clk;

  typedef struct { logic [31:0] d; logic [23:0] blk; } exp_t;
  exp_t        q[$];
  logic [31:0] mem [0:255];
  int checks = 0, fails = 0, cyc = 0, xfers = 0, abort_at = 0;
  int done_cnt = 0, ready_mode = 0, lat = 0, req_n = 0;
  logic prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
    if (mem_valid) begin
      mem_valid = 1'b0; lat = 0; req_n++;
    end else if (mem_req) begin
      if (lat >= req_n % 3) begin
        mem_valid = 1'b1;
        mem_rdata = mem[mem_addr[9:2]];
      end else lat++;
    end
    case (ready_mode)
      0: per_ready = (cyc % 5) != 1;
      1: per_ready = (cyc % 4) == 0;
      default: per_ready = 1'b1;
    endcase
    if (done) begin
      done_cnt++;
      chk(!busy, "R8 busy low with done", 32'(busy), 32'd0);
      chk(!prev_done, "R8 done single cycle", 32'(prev_done), 32'd0);
    end
    prev_done = done;
    if (per_valid && per_ready) begin
      xfers++;
      if (q.size() == 0) chk(1'b0, "R7 unexpected word", per_data, 32'hx);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(per_data === e.d, "R2 payload word", per_data, e.d);
        chk(cur_addr === e.blk, "R5 block start while busy", 32'(cur_addr), 32'(e.blk));
      end
    end
    abort_hit = (abort_at != 0) && (xfers >= abort_at);
  end

  task automatic node(input logic [23:0] a, input int n, input logic [23:0] nxt, input bit push);
    mem[a[9:2]] = {8'(n), nxt};
    for (int i = 1; i <= n; i++) begin
      exp_t e;
      mem[a[9:2] + 8'(i)] = {a[7:0], 8'(i), 16'hC0DE ^ 16'(a)};
      e.d = mem[a[9:2] + 8'(i)];
      e.blk = {a[23:2], 2'b00};
      if (push) q.push_back(e);
    end
  endtask

  task automatic wr_addr(input logic [23:0] v);
    @(negedge clk); addr_we = 1'b1; addr_wdata = v;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  int d0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !per_valid, "R1 reset idle",
        {busy, done, mem_req, per_valid}, 32'd0);
    chk(cur_addr == 24'd0, "R5 reset address", 32'(cur_addr), 32'd0);
    rst_n = 1'b1;
    en_main = 1'b1;

    // three-node chain, unaligned start, zero-count middle node
    wr_addr(24'h000013);
    chk(cur_addr == 24'h000013, "R6 low bits writable", 32'(cur_addr), 32'h13);
    node(24'h000010, 3, 24'h000040, 1);
    node(24'h000040, 0, 24'h000080, 1);
    node(24'h000080, 2, 24'hFFFFFF, 1);
    ready_mode = 0;
    d0 = done_cnt;
    pulse_start();
    chk(busy, "R1 busy after start", 32'(busy), 32'd1);
    wait_idle();
    chk(q.size() == 0, "R3 all words delivered", q.size(), 0);
    chk(done_cnt == d0 + 1, "R8 one done", done_cnt - d0, 1);
    chk(cur_addr == 24'hFFFFFC, "R5 end marker aligned", 32'(cur_addr), 32'hFFFFFC);

    // non-standard end marker and write while busy
    wr_addr(24'h000200);
    node(24'h000200, 1, 24'h800002, 1);
    ready_mode = 1;
    d0 = done_cnt;
    pulse_start();
    chk(busy, "R10 busy during write", 32'(busy), 32'd1);
    @(negedge clk); addr_we = 1'b1; addr_wdata = 24'h000123;
    @(negedge clk); addr_we = 1'b0;
    wait_idle();
    chk(cur_addr == 24'h800000, "R4 R10 end value kept", 32'(cur_addr), 32'h800000);
    chk(done_cnt == d0 + 1, "R4 done on bit23", done_cnt - d0, 1);
    chk(q.size() == 0, "R7 backpressure words", q.size(), 0);

    // unaligned link, terminal node of zero count
    wr_addr(24'h000100);
    node(24'h000100, 1, 24'h0000A2, 1);
    node(24'h0000A0, 0, 24'hC00001, 1);
    ready_mode = 2;
    d0 = done_cnt;
    pulse_start();
    wait_idle();
    chk(cur_addr == 24'hC00000, "R4 R5 marker low bits cleared", 32'(cur_addr), 32'hC00000);
    chk(done_cnt == d0 + 1, "R3 zero-count end node", done_cnt - d0, 1);
    chk(q.size() == 0, "R5 link realigned", q.size(), 0);

    // enable cleared after two words
    wr_addr(24'h000300);
    node(24'h000300, 4, 24'hFFFFFF, 0);
    for (int i = 1; i <= 2; i++) begin
      exp_t e;
      e.d = mem[8'hC0 + 8'(i)]; e.blk = 24'h000300;
      q.push_back(e);
    end
    ready_mode = 0;
    d0 = done_cnt;
    abort_at = xfers + 2;
    pulse_start();
    wait_idle();
    repeat (10) @(negedge clk);
    chk(!busy, "R9 stopped", 32'(busy), 32'd0);
    chk(q.size() == 0, "R9 two words only", q.size(), 0);
    chk(done_cnt == d0, "R9 no done", done_cnt - d0, 0);
    chk(cur_addr == 24'h000300, "R9 address at block start", 32'(cur_addr), 32'h300);
    abort_at = 0;
    @(negedge clk);
    node(24'h000300, 4, 24'hFFFFFF, 1);
    pulse_start();
    wait_idle();
    chk(q.size() == 0, "R9 replay whole node", q.size(), 0);
    chk(done_cnt == d0 + 1, "R9 done after replay", done_cnt - d0, 1);
    chk(cur_addr == 24'hFFFFFC, "R5 end after replay", 32'(cur_addr), 32'hFFFFFC);

    finish_run();
  end
endmodule